// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers bytes from an asynchronous serial line. It uses a 16x oversampling enable that a separate rate generator supplies. A falling edge on the idle-high line arms the receiver. The start bit is confirmed at its centre, and each later bit is sampled at its own centre. The word is 5 to 8 bits wide, least significant bit first. An optional parity bit and a stop bit follow the word. The word-length and parity settings come from the same configuration that drives the companion transmitter.

A completed frame lands in a holding register and sets a full flag. The host clears the full flag with a one-cycle read strobe. Every completed frame refreshes three error flags: parity mismatch, missing stop bit, and overrun. An overrun happens when a frame completes before the previous byte was read. In that case the old byte is kept and the new byte is dropped. A ready-to-receive input, active low, stops new frames from being accepted. An echo mode sends the incoming line straight back out on the transmit pin in place of the transmitter's own output.

Top module: `serial_rx_core`

## Requirements
- R1: After synchronous reset, `rx_full`, `rx_data`, `err_parity`, `err_frame` and `err_overrun` are all 0 and `tx_out` is 1.
- R2: Data bits are received least significant bit first. `len_sel` selects the word length: 00 = 8 bits, 01 = 7, 10 = 6, 11 = 5. Bits of `rx_data` above the word length read as 0.
- R3: A low level that does not last until the eighth oversampling tick after the falling edge is treated as noise. It produces no frame.
- R4: When `par_en` is 1, one parity bit follows the data and is checked according to `par_mode`: 00 = odd, 01 = even, 10 = mark (bit must be 1), 11 = space (bit must be 0). A mismatch sets `err_parity`. When `par_en` is 0, no parity bit is expected and `err_parity` is 0.
- R5: If the first stop bit is sampled low, `err_frame` is set. The receiver then waits for the line to return high before it accepts another start bit.
- R6: A completed frame loads `rx_data` and sets `rx_full`. A one-cycle `rd_strobe` clears `rx_full`.
- R7: If a frame completes while `rx_full` is still 1 and no read is strobed, `err_overrun` is set and `rx_data` keeps the unread byte. A frame that completes with the register free clears `err_overrun`.
- R8: While `rts_n` is 1, no new frame is started, so a frame sent in that time is not received.
- R9: `err_parity`, `err_frame` and `err_overrun` change only when a frame completes, and they describe that latest frame. A read does not alter them.
- R10: `tx_out` is registered. It follows `rx_line` one cycle later when `echo_en` is 1, and `tx_in` one cycle later when `echo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit time |
| rx_line | input | 1 | Serial input, idles high |
| rts_n | input | 1 | Ready to receive, active low |
| len_sel | input | 2 | Word length code |
| par_en | input | 1 | Parity bit present |
| par_mode | input | 2 | Parity kind: odd, even, mark, space |
| echo_en | input | 1 | Loop the received line back to `tx_out` |
| tx_in | input | 1 | Transmitter serial output |
| rd_strobe | input | 1 | Data read, clears the full flag |
| rx_data | output | 8 | Received word, zero-extended |
| rx_full | output | 1 | Holding register holds an unread word |
| err_parity | output | 1 | Latest frame failed its parity check |
| err_frame | output | 1 | Latest frame's first stop bit was low |
| err_overrun | output | 1 | Latest frame arrived while the register was full |
| tx_out | output | 1 | Serial output to the line |

## Verification
The bench runs every parity kind with both a correct and a corrupted parity bit. A design with odd and even swapped, or one that ignores mark and space, would flag the wrong frames. It sends a 6-bit and a 5-bit word with all-ones source data, which catches a word-length decoder that shifts in extra bits. A frame with a low stop bit must be followed by a clean frame. A receiver that re-arms while the line is still low would take the tail of the bad stop bit as a start bit and lose sync. A two-tick noise pulse, a frame sent while not ready, and a second frame that lands on an unread byte cover three more faults: false starts, ignoring the ready line, and overwriting the held byte.

// File: rtl/srx_pkg.sv
package srx_pkg;

  // Receiver sequencing states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } srx_state_t;

  // Parity kind encoding shared with the transmitter side
  localparam logic [1:0] PAR_ODD   = 2'b00;
  localparam logic [1:0] PAR_EVEN  = 2'b01;
  localparam logic [1:0] PAR_MARK  = 2'b10;
  localparam logic [1:0] PAR_SPACE = 2'b11;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= 1'b1;
        else     chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxs,
  input  logic              rts_n,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output logic              par_bit,
  output logic              stop_ok,
  output srx_state_t        state
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;

  assign last_idx = IDX_W'(DATA_W - 1) - IDX_W'(len_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      word    <= '0;
      par_bit <= 1'b0;
      stop_ok <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            cnt_q <= '0;
            if (!rts_n && !rxs) state <= ST_START;
          end
          ST_START: begin
            if (cnt_q == MID_CNT) begin
              cnt_q <= '0;
              idx_q <= '0;
              if (!rxs) begin
                word  <= '0;
                state <= ST_DATA;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt_q == LAST_CNT) begin
              cnt_q       <= '0;
              word[idx_q] <= rxs;
              if (idx_q == last_idx) state <= par_en ? ST_PAR : ST_STOP;
              else                   idx_q <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt_q == LAST_CNT) begin
              cnt_q   <= '0;
              par_bit <= rxs;
              state   <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == LAST_CNT) begin
              cnt_q   <= '0;
              stop_ok <= rxs;
              done    <= 1'b1;
              state   <= rxs ? ST_IDLE : ST_HOLD;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_HOLD: begin
            if (rxs) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/srx_parity.sv
module srx_parity
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] word,
  input  logic              par_bit,
  input  logic              par_en,
  input  logic [1:0]        par_mode,
  output logic              mismatch
);
  logic odd_total;

  // unused high bits of the word are cleared at start, so a plain reduction works
  assign odd_total = (^word) ^ par_bit;

  always_comb begin
    mismatch = 1'b0;
    if (par_en) begin
      case (par_mode)
        PAR_ODD:   mismatch = !odd_total;
        PAR_EVEN:  mismatch = odd_total;
        PAR_MARK:  mismatch = !par_bit;
        default:   mismatch = par_bit;
      endcase
    end
  end
endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] word,
  input  logic              par_bad,
  input  logic              stop_ok,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_full     <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else if (done) begin
      err_parity <= par_bad;
      err_frame  <= !stop_ok;
      if (rx_full && !rd_strobe) begin
        err_overrun <= 1'b1;
      end else begin
        rx_data     <= word;
        rx_full     <= 1'b1;
        err_overrun <= 1'b0;
      end
    end else if (rd_strobe) begin
      rx_full <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rx_line,
  input  logic              rts_n,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic [1:0]        par_mode,
  input  logic              echo_en,
  input  logic              tx_in,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              tx_out
);
  logic              rx_sync;
  logic              frame_done;
  logic [DATA_W-1:0] frame_word;
  logic              frame_par;
  logic              frame_stop_ok;
  logic              par_bad;
  srx_state_t        fr_state;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_line), .dout(rx_sync)
  );

  srx_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_framer (
    .clk(clk), .rst(rst), .tick(tick16), .rxs(rx_sync), .rts_n(rts_n),
    .len_sel(len_sel), .par_en(par_en), .done(frame_done), .word(frame_word),
    .par_bit(frame_par), .stop_ok(frame_stop_ok), .state(fr_state)
  );

  srx_parity #(.DATA_W(DATA_W)) u_parity (
    .word(frame_word), .par_bit(frame_par), .par_en(par_en),
    .par_mode(par_mode), .mismatch(par_bad)
  );

  srx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .done(frame_done), .word(frame_word),
    .par_bad(par_bad), .stop_ok(frame_stop_ok), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_full(rx_full), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun)
  );

  // echo or transmitter path to the line
  always_ff @(posedge clk) begin
    if (rst) tx_out <= 1'b1;
    else     tx_out <= echo_en ? rx_line : tx_in;
  end
endmodule

// File: rtl/srx_checks.sv
module srx_checks
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_strobe,
  input logic              rx_full,
  input logic [DATA_W-1:0] rx_data,
  input logic              err_parity,
  input logic              err_frame,
  input logic              err_overrun,
  input logic              echo_en,
  input logic              rx_line,
  input logic              tx_out,
  input logic              rts_n,
  input logic              frame_done,
  input srx_state_t        fr_state
);
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !frame_done) |=> !rx_full); // R6

  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (frame_done && rx_full && !rd_strobe) |=> (err_overrun && rx_full && rx_data == $past(rx_data))); // R7

  AST_NO_START_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (rts_n && fr_state == ST_IDLE) |=> fr_state == ST_IDLE); // R8

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> ($stable(err_parity) && $stable(err_frame) && $stable(err_overrun))); // R9

  AST_ECHO_PATH: assert property (@(posedge clk) disable iff (rst)
    echo_en |=> tx_out == $past(rx_line)); // R10
endmodule

bind serial_rx_core srx_checks #(.DATA_W(DATA_W)) u_checks (
  .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .rx_full(rx_full),
  .rx_data(rx_data), .err_parity(err_parity), .err_frame(err_frame),
  .err_overrun(err_overrun), .echo_en(echo_en), .rx_line(rx_line),
  .tx_out(tx_out), .rts_n(rts_n), .frame_done(frame_done), .fr_state(fr_state)
);

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;
  localparam int TICK_DIV = 3;
  localparam int BIT_CLK  = 16 * TICK_DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_line = 1'b1;
  logic rts_n = 1'b0;
  logic [1:0] len_sel = 2'b00;
  logic par_en = 1'b0;
  logic [1:0] par_mode = 2'b00;
  logic echo_en = 1'b0;
  logic tx_in = 1'b1;
  logic rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, err_parity, err_frame, err_overrun, tx_out;
  logic tick16;
  int   tdiv = 0;

  int n_chk = 0;
  int n_bad = 0;
  bit auto_rd = 1'b1;

  typedef struct { logic [7:0] d; logic pe; logic fe; logic ov; } exp_t;
  exp_t sb[$];

  always #2 clk = !clk;

  always @(posedge clk) tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
  assign tick16 = (tdiv == 0);

  serial_rx_core uut (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_line(rx_line), .rts_n(rts_n),
    .len_sel(len_sel), .par_en(par_en), .par_mode(par_mode), .echo_en(echo_en),
    .tx_in(tx_in), .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
    .tx_out(tx_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic v);
    rx_line = v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  // drives one frame; optionally queues the expected result
  task automatic send_frame(input logic [7:0] d, input bit push, input bit bad_par,
                            input logic stop_v);
    int   nb;
    logic pb;
    logic [7:0] dm;
    exp_t e;
    nb = 8 - int'(len_sel);
    dm = d & 8'(( 9'd1 << nb) - 1);
    case (par_mode)
      2'b00:   pb = !(^dm);
      2'b01:   pb = ^dm;
      2'b10:   pb = 1'b1;
      default: pb = 1'b0;
    endcase
    if (push) begin
      e.d = dm; e.pe = par_en && bad_par; e.fe = !stop_v; e.ov = 1'b0;
      sb.push_back(e);
    end
    @(negedge clk);
    bit_out(1'b0);
    for (int i = 0; i < nb; i++) bit_out(d[i]);
    if (par_en) bit_out(pb ^ bad_par);
    bit_out(stop_v);
    bit_out(1'b1);
    if (push) while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic read_pulse();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  // scoreboard monitor: compares and reads out each received word
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (auto_rd && rx_full && !rd_strobe) begin
        if (sb.size() == 0) begin
          chk("R6 unexpected frame", 32'(rx_data), 32'hFFFF);
        end else begin
          e = sb.pop_front();
          chk("R2 data", 32'(rx_data), 32'(e.d));
          chk("R4 parity flag", 32'(err_parity), 32'(e.pe));
          chk("R5 frame flag", 32'(err_frame), 32'(e.fe));
          chk("R7 overrun flag", 32'(err_overrun), 32'(e.ov));
        end
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        chk("R6 full cleared", 32'(rx_full), 32'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 full", 32'(rx_full), 0);
    chk("R1 data", 32'(rx_data), 0);
    chk("R1 flags", 32'({err_parity, err_frame, err_overrun}), 0);
    chk("R1 tx_out", 32'(tx_out), 1);

    // R2 eight bits, no parity
    len_sel = 2'b00; par_en = 1'b0;
    send_frame(8'hA5, 1, 0, 1'b1);
    send_frame(8'h3C, 1, 0, 1'b1);
    // R4 even, 7 bits
    len_sel = 2'b01; par_en = 1'b1; par_mode = 2'b01;
    send_frame(8'h55, 1, 0, 1'b1);
    send_frame(8'h55, 1, 1, 1'b1);
    // R4 odd, R2 six bits
    len_sel = 2'b10; par_mode = 2'b00;
    send_frame(8'hFF, 1, 0, 1'b1);
    send_frame(8'h29, 1, 1, 1'b1);
    // R4 mark, R2 five bits
    len_sel = 2'b11; par_mode = 2'b10;
    send_frame(8'hFF, 1, 0, 1'b1);
    send_frame(8'h13, 1, 1, 1'b1);
    // R4 space
    len_sel = 2'b00; par_mode = 2'b11;
    send_frame(8'h80, 1, 0, 1'b1);
    send_frame(8'h80, 1, 1, 1'b1);

    // R5 framing error then clean frame
    par_en = 1'b0;
    send_frame(8'h0F, 1, 0, 1'b0);
    send_frame(8'hC3, 1, 0, 1'b1);

    // R3 short low pulse is rejected
    @(negedge clk); rx_line = 1'b0;
    repeat (2 * TICK_DIV) @(negedge clk);
    rx_line = 1'b1;
    repeat (4 * BIT_CLK) @(negedge clk);
    chk("R3 glitch no frame", 32'(rx_full), 0);
    send_frame(8'h5A, 1, 0, 1'b1);

    // R8 not ready
    rts_n = 1'b1;
    send_frame(8'h99, 0, 0, 1'b1);
    repeat (BIT_CLK) @(negedge clk);
    chk("R8 no receive while not ready", 32'(rx_full), 0);
    rts_n = 1'b0;
    send_frame(8'h66, 1, 0, 1'b1);

    // R7 overrun keeps the unread byte
    auto_rd = 1'b0;
    par_en = 1'b1; par_mode = 2'b01;
    send_frame(8'h11, 0, 0, 1'b1);
    chk("R6 full set", 32'(rx_full), 1);
    chk("R7 no overrun yet", 32'(err_overrun), 0);
    send_frame(8'h22, 0, 1, 1'b1);
    chk("R7 data kept", 32'(rx_data), 32'h11);
    chk("R7 overrun set", 32'(err_overrun), 1);
    chk("R9 parity of latest frame", 32'(err_parity), 1);
    read_pulse();
    @(negedge clk);
    chk("R6 read clears full", 32'(rx_full), 0);
    chk("R9 flags kept by read", 32'({err_parity, err_overrun}), 32'b11);
    auto_rd = 1'b1;
    send_frame(8'h33, 1, 0, 1'b1);

    // R10 echo and pass-through
    rts_n = 1'b1;
    echo_en = 1'b1;
    @(negedge clk); rx_line = 1'b0;
    @(negedge clk); chk("R10 echo low", 32'(tx_out), 0);
    rx_line = 1'b1;
    @(negedge clk); chk("R10 echo high", 32'(tx_out), 1);
    echo_en = 1'b0; tx_in = 1'b0;
    @(negedge clk); chk("R10 tx pass low", 32'(tx_out), 0);
    tx_in = 1'b1;
    @(negedge clk); chk("R10 tx pass high", 32'(tx_out), 1);

    repeat (10) @(negedge clk);
    chk("R6 scoreboard drained", 32'(sb.size()), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule